// File: doc/BRIEF.md
# Ping-Pong Buffered PWM Generator

This block produces one pulse-width-modulated output from a free-running counter and two compare registers, A and B. Each register has its own write strobe. When the link control is set, the two registers take turns as the width source. Software writes the new width into the register that is not in use. That register then takes over at the next counter overflow, so every period runs with a single width. A one-bit record of which register was written last decides the source at each overflow. No hidden shadow copy is kept.

When the pair is linked, the second output pin is released from the timer. It then carries a general-purpose data/enable pair. When the pair is unlinked, the block works as two plain PWM channels: the main output uses register A and the second pin uses register B. All ports are plain control and data pins. Writes are single-cycle strobes, so no valid/ready handshake applies and there is no back-pressure.

Top module: `pingpong_pwm`

## Requirements
- R1: After reset the counter is 0, both compare registers are 0, register A is the width source, and `pwm_o` stays low for the whole first period.
- R2: The counter counts 0, 1, … up to `modulo_i`, then returns to 0. The cycle in which it equals `modulo_i` is the overflow cycle.
- R3: `pwm_o` is 1 exactly while the counter is below the active compare value. A value of 0 keeps the output low for the whole period. A value above `modulo_i` keeps it high for the whole period.
- R4: While unlinked, register A is always the width source. When the link is raised, register A stays the source until an overflow chooses otherwise. Clearing the link returns control to A in the next cycle.
- R5: While linked, a write to the inactive register leaves the current period unchanged. That register becomes the source starting at counter value 0 of the next period.
- R6: While linked, a write to the active register changes the width starting in the next cycle, within the current period.
- R7: At each overflow the source becomes the register written most recently. A write in the overflow cycle itself counts for the new period. If both strobes are set in the same cycle, B counts as the later write.
- R8: While linked, `pin_b_o` equals `gpio_data_i` and `pin_b_oe_o` equals `gpio_oe_i`. `b_out_en_i` has no effect.
- R9: While unlinked, `pin_b_o` is 1 while the counter is below compare register B, and `pin_b_oe_o` equals `b_out_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modulo_i | input | 16 | Last counter value of a period |
| link_en_i | input | 1 | Pairs registers A and B as one buffered channel |
| cmp_a_wr_i | input | 1 | Write strobe for compare register A |
| cmp_a_data_i | input | 16 | Write data for register A |
| cmp_b_wr_i | input | 1 | Write strobe for compare register B |
| cmp_b_data_i | input | 16 | Write data for register B |
| b_out_en_i | input | 1 | Second channel output enable (used only while unlinked) |
| gpio_data_i | input | 1 | General-purpose value for the second pin while linked |
| gpio_oe_i | input | 1 | General-purpose enable for the second pin while linked |
| pwm_o | output | 1 | PWM output |
| pin_b_o | output | 1 | Second pin value |
| pin_b_oe_o | output | 1 | Second pin output enable |

## Verification
The bench aims at the overflow boundary. A write placed in the overflow cycle must govern the new period. If the design sampled the last-written flag one cycle late, that period would run with the old width. Writes to the inactive register in the middle of a period are checked against the remaining cycles of that period. A design that switched at once, with no buffering, would cut the pulse short or stretch it. The bench also sets both strobes in the same cycle, where a design that let A win would choose the wrong source. Compare values of 0 and above the modulo are checked too, because an off-by-one comparison would produce a one-cycle glitch at the edges of the period.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_e;
endpackage

// File: rtl/pp_pwm_counter.sv
module pp_pwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] modulo_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;

  assign ovf_o = (cnt_q == modulo_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (ovf_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == modulo_i) |=> (cnt_q == '0));
endmodule

// File: rtl/pp_pwm_select.sv
module pp_pwm_select
  import pp_pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         link_i,
  input  logic         ovf_i,
  input  logic         a_wr_i,
  input  logic [W-1:0] a_data_i,
  input  logic         b_wr_i,
  input  logic [W-1:0] b_data_i,
  output logic [W-1:0] cmp_act_o,
  output logic [W-1:0] cmp_b_o
);
  logic [W-1:0] cmp_a_q, cmp_b_q;
  src_e         sel_q, last_q, last_nx;

  always_comb begin
    last_nx = last_q;
    if (a_wr_i) last_nx = SRC_A;
    if (b_wr_i) last_nx = SRC_B;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      sel_q   <= SRC_A;
      last_q  <= SRC_A;
    end else begin
      if (a_wr_i) cmp_a_q <= a_data_i;
      if (b_wr_i) cmp_b_q <= b_data_i;
      if (!link_i) begin
        sel_q  <= SRC_A;
        last_q <= SRC_A;
      end else begin
        last_q <= last_nx;
        if (ovf_i) sel_q <= last_nx;
      end
    end
  end

  assign cmp_act_o = (sel_q == SRC_B) ? cmp_b_q : cmp_a_q;
  assign cmp_b_o   = cmp_b_q;

  // R4
  unlinked_src_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_i |=> (sel_q == SRC_A));
  // R5
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i && !ovf_i) |=> $stable(sel_q));
  // R6
  active_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i && a_wr_i && !b_wr_i && sel_q == SRC_A && !ovf_i) |=> (cmp_act_o == $past(a_data_i)));
endmodule

// File: rtl/pp_pwm_outputs.sv
module pp_pwm_outputs #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_act_i,
  input  logic [W-1:0] cmp_b_i,
  input  logic         link_i,
  input  logic         b_out_en_i,
  input  logic         gpio_data_i,
  input  logic         gpio_oe_i,
  output logic         pwm_o,
  output logic         pin_b_o,
  output logic         pin_b_oe_o
);
  logic b_pwm;

  assign pwm_o = (cnt_i < cmp_act_i);
  assign b_pwm = (cnt_i < cmp_b_i);

  always_comb begin
    if (link_i) begin
      pin_b_o    = gpio_data_i;
      pin_b_oe_o = gpio_oe_i;
    end else begin
      pin_b_o    = b_pwm;
      pin_b_oe_o = b_out_en_i;
    end
  end
endmodule

// File: rtl/pingpong_pwm.sv
module pingpong_pwm #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] modulo_i,
  input  logic         link_en_i,
  input  logic         cmp_a_wr_i,
  input  logic [W-1:0] cmp_a_data_i,
  input  logic         cmp_b_wr_i,
  input  logic [W-1:0] cmp_b_data_i,
  input  logic         b_out_en_i,
  input  logic         gpio_data_i,
  input  logic         gpio_oe_i,
  output logic         pwm_o,
  output logic         pin_b_o,
  output logic         pin_b_oe_o
);
  logic [W-1:0] cnt, cmp_act, cmp_b;
  logic         ovf;

  pp_pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .modulo_i(modulo_i), .cnt_o(cnt), .ovf_o(ovf)
  );

  pp_pwm_select #(.W(W)) u_sel (
    .clk(clk), .rst_n(rst_n), .link_i(link_en_i), .ovf_i(ovf),
    .a_wr_i(cmp_a_wr_i), .a_data_i(cmp_a_data_i),
    .b_wr_i(cmp_b_wr_i), .b_data_i(cmp_b_data_i),
    .cmp_act_o(cmp_act), .cmp_b_o(cmp_b)
  );

  pp_pwm_outputs #(.W(W)) u_out (
    .cnt_i(cnt), .cmp_act_i(cmp_act), .cmp_b_i(cmp_b), .link_i(link_en_i),
    .b_out_en_i(b_out_en_i), .gpio_data_i(gpio_data_i), .gpio_oe_i(gpio_oe_i),
    .pwm_o(pwm_o), .pin_b_o(pin_b_o), .pin_b_oe_o(pin_b_oe_o)
  );
endmodule

// File: tb/pingpong_pwm_tb_top.sv
`timescale 1ns/1ps
module pingpong_pwm_tb_top;
  localparam int MOD = 9;
  localparam int PER = MOD + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_en = 1'b0, a_wr = 1'b0, b_wr = 1'b0;
  logic [15:0] a_data = '0, b_data = '0;
  logic        b_out_en = 1'b0, gpio_data = 1'b0, gpio_oe = 1'b0;
  logic        pwm, pin_b, pin_b_oe;
  int          cyc = 0;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pingpong_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .modulo_i(16'(MOD)), .link_en_i(link_en),
    .cmp_a_wr_i(a_wr), .cmp_a_data_i(a_data),
    .cmp_b_wr_i(b_wr), .cmp_b_data_i(b_data),
    .b_out_en_i(b_out_en), .gpio_data_i(gpio_data), .gpio_oe_i(gpio_oe),
    .pwm_o(pwm), .pin_b_o(pin_b), .pin_b_oe_o(pin_b_oe)
  );

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic step(); @(negedge clk); endtask
  task automatic wait_phase(int p); while ((cyc % PER) != p) step(); endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // checks pwm over phases start..MOD against the given width
  task automatic check_span(int start, int w, string req);
    int bad = 0;
    wait_phase(start);
    for (int p = start; p < PER; p++) begin
      if (pwm !== (p < w)) bad++;
      step();
    end
    chk(req, bad, 0);
  endtask

  task automatic wr_a(int v);
    a_data = 16'(v); a_wr = 1'b1; step(); a_wr = 1'b0;
  endtask
  task automatic wr_b(int v);
    b_data = 16'(v); b_wr = 1'b1; step(); b_wr = 1'b0;
  endtask
  task automatic wr_both(int va, int vb);
    a_data = 16'(va); b_data = 16'(vb); a_wr = 1'b1; b_wr = 1'b1; step();
    a_wr = 1'b0; b_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pwm after reset", pwm, 0);
    chk("R9 oe after reset", pin_b_oe, 0);
    check_span(0, 0, "R1 first period low");
  endtask

  task automatic t_unbuffered();
    wait_phase(5); wr_a(4);
    check_span(6, 4, "R3 immediate unlinked");
    check_span(0, 4, "R3 width 4");
    wait_phase(MOD); wr_a(15);
    check_span(0, PER, "R3 above modulo full high");
    wait_phase(MOD); wr_a(0);
    check_span(0, 0, "R3 zero full low");
    wait_phase(MOD); wr_a(4);
  endtask

  task automatic t_link();
    int bad = 0;
    b_out_en = 1'b1;
    wait_phase(MOD); wr_b(8);
    wait_phase(0);
    for (int p = 0; p < PER; p++) begin
      if (pin_b !== (p < 8) || pin_b_oe !== 1'b1) bad++;
      step();
    end
    chk("R9 unlinked pin b pwm", bad, 0);
    wait_phase(0); link_en = 1'b1;
    check_span(0, 4, "R4 A first after link");
    check_span(0, 4, "R4 A holds");
    wait_phase(2); wr_b(7);
    check_span(3, 4, "R5 current period unchanged");
    check_span(0, 7, "R5 B from next period");
  endtask

  task automatic t_active();
    wait_phase(1); wr_b(2);
    check_span(2, 2, "R6 active write immediate");
    check_span(0, 2, "R6 holds next period");
  endtask

  task automatic t_order();
    wait_phase(1); wr_a(3); wr_b(6);
    check_span(3, 6, "R7 B active immediate");
    check_span(0, 6, "R7 B written last");
    wait_phase(1); wr_b(5); wr_a(8);
    check_span(3, 5, "R7 current B kept");
    check_span(0, 8, "R7 A written last");
    wait_phase(4); wr_both(1, 9);
    check_span(5, 1, "R7 active A rewritten");
    check_span(0, 9, "R7 same cycle B wins");
    wait_phase(MOD); wr_a(5);
    check_span(0, 5, "R7 write at overflow");
  endtask

  task automatic t_pins();
    gpio_data = 1'b1; gpio_oe = 1'b1; b_out_en = 1'b1; step();
    chk("R8 gpio data", pin_b, 1);
    chk("R8 gpio oe", pin_b_oe, 1);
    gpio_data = 1'b0; gpio_oe = 1'b0; step();
    chk("R8 b_out_en ignored", pin_b_oe, 0);
    chk("R8 gpio data low", pin_b, 0);
    wait_phase(0); wr_a(5); wr_b(9);
    wait_phase(0); link_en = 1'b0; step();
    check_span(1, 5, "R4 unlink returns to A");
    chk("R9 oe follows enable", pin_b_oe, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    t_reset();
    t_unbuffered();
    t_link();
    t_active();
    t_order();
    t_pins();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule